// File: doc/BRIEF.md
# Control Endpoint Handshake and Status Logic

This block decides the device-side reply to each token on a single USB control endpoint that owns one data bank, and keeps the status flags that firmware polls to run control transfers. Each cycle it may see one decoded token: SETUP, OUT or IN. With the token come a flag that says whether the attached data arrived intact and a retry-required input from the transfer layer. One cycle later it reports the reply. For a SETUP or an OUT the reply is an ACK, NAK or STALL handshake. For an IN it is a NAK, a STALL or a data-send strobe.

Firmware reaches four flags through one write port. Each flag is cleared by writing 0 to its bit:

- setup received, bit 0
- OUT received, bit 1
- IN bank ready, bit 2
- NAK sent on IN, bit 3

Firmware also sets or clears a stall request. The bank-control bits (FIFO control and read/write allowed) have no meaning on a control endpoint. They read back as zero and writes to them are dropped.

The fixed priorities are as follows. A good SETUP is always acknowledged and lifts any stall. For OUT and IN tokens, a required retry beats a stall request. A stall request beats the bank-occupancy checks.

Top module: `usb_ctrl_ep_hs`

## Requirements
- R1: An OUT token with good data, or an IN token, that arrives while retry_i is high is answered with NAK (hs_code_o = 2), even when a stall is requested.
- R2: STALL (hs_code_o = 3) is returned only when the stall request is set and retry_i is low at the token. An OUT with good data or an IN under those conditions gets STALL.
- R3: A SETUP with good data is answered with ACK (hs_code_o = 1) whatever the retry, stall and flag state. A SETUP or OUT whose data is not intact gets no reply (hs_valid_o low) and changes no flag.
- R4: A good SETUP sets the setup flag (bit 0) and never sets the OUT flag (bit 1).
- R5: An OUT with good data is answered with ACK and sets the OUT flag when retry is low, no stall is requested, and neither the setup flag nor the OUT flag is set.
- R6: An OUT with good data that arrives while the setup flag or the OUT flag is set is answered with NAK, and the flags keep their values.
- R7: The IN-ready flag (bit 2) is 1 after reset. An IN token (no retry, no stall) that arrives while it is set is answered with NAK. Once firmware has cleared it, the next such IN token pulses tx_data_o with hs_valid_o low, and the flag sets again.
- R8: Every NAK given to an IN token sets the NAK-on-IN flag (bit 3). IN tokens answered otherwise leave it unchanged.
- R9: A flag write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. When a hardware set and a firmware clear meet in one cycle, the flag ends up set.
- R10: bank_rd_o always reads 0, including after any write on the bank-control port.
- R11: A good SETUP clears the stall request, and this wins over a firmware stall write made in the same cycle.
- R12: The reply appears in the cycle after the token, for exactly one cycle. hs_valid_o is never high without a token one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_setup_i | input | 1 | SETUP token seen this cycle |
| tok_out_i | input | 1 | OUT token seen this cycle |
| tok_in_i | input | 1 | IN token seen this cycle |
| rx_ok_i | input | 1 | Data attached to SETUP/OUT arrived intact |
| retry_i | input | 1 | Transfer layer requires a retry |
| fw_flag_we_i | input | 1 | Firmware write to the flag register |
| fw_flag_wdata_i | input | 4 | Flag write data; a 0 bit clears that flag |
| fw_stall_we_i | input | 1 | Firmware write to the stall request |
| fw_stall_i | input | 1 | Stall request value to write |
| fw_bank_we_i | input | 1 | Firmware write to the bank-control bits |
| fw_bank_wdata_i | input | 2 | Bank-control write data (ignored) |
| hs_valid_o | output | 1 | A handshake is sent this cycle |
| hs_code_o | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| tx_data_o | output | 1 | Committed IN bank is sent this cycle |
| flags_o | output | 4 | {nak_in, in_ready, out_rx, setup_rx} |
| stall_req_o | output | 1 | Current stall request |
| bank_rd_o | output | 2 | Bank-control read value, always 0 |

## Verification
The bank-occupancy and stall states are invisible except through replies. A flag that fails to set is shown by the next token, which is ACKed where a NAK was due. A stall that survives a SETUP is shown by a STALL to the following data token. Because every reply is registered once, a wrong decision reaches hs_code_o exactly one cycle after its token, and the flag effects show at the same edge. The bench therefore issues each token and compares the reply and the flags on the next cycle. It also walks the retry/stall/occupancy priority from each side.

// File: rtl/usb_ctrl_ep_pkg.sv
package usb_ctrl_ep_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned BANK_W    = 2;

  localparam int unsigned F_SETUP = 0;
  localparam int unsigned F_OUT   = 1;
  localparam int unsigned F_INRDY = 2;
  localparam int unsigned F_NAKIN = 3;

  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 4'b0100;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;
endpackage

// File: rtl/usb_ctrl_ep_resp.sv
module usb_ctrl_ep_resp
  import usb_ctrl_ep_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAGS
) (
  input  logic          tok_setup_i,
  input  logic          tok_out_i,
  input  logic          tok_in_i,
  input  logic          rx_ok_i,
  input  logic          retry_i,
  input  logic          stall_i,
  input  logic [NF-1:0] flags_i,
  output logic          hs_vld_o,
  output hs_code_e      hs_code_o,
  output logic          tx_o,
  output logic [NF-1:0] set_o,
  output logic          clr_stall_o
);
  logic bank_busy;
  assign bank_busy = flags_i[F_SETUP] | flags_i[F_OUT];

  always_comb begin
    hs_vld_o    = 1'b0;
    hs_code_o   = HS_NONE;
    tx_o        = 1'b0;
    set_o       = '0;
    clr_stall_o = 1'b0;
    if (tok_setup_i && rx_ok_i) begin
      // setup ignores retry, stall and bank state
      hs_vld_o       = 1'b1;
      hs_code_o      = HS_ACK;
      set_o[F_SETUP] = 1'b1;
      clr_stall_o    = 1'b1;
    end else if (tok_out_i && rx_ok_i) begin
      hs_vld_o = 1'b1;
      if (retry_i)        hs_code_o = HS_NAK;
      else if (stall_i)   hs_code_o = HS_STALL;
      else if (bank_busy) hs_code_o = HS_NAK;
      else begin
        hs_code_o    = HS_ACK;
        set_o[F_OUT] = 1'b1;
      end
    end else if (tok_in_i) begin
      if (retry_i || (!stall_i && flags_i[F_INRDY])) begin
        hs_vld_o       = 1'b1;
        hs_code_o      = HS_NAK;
        set_o[F_NAKIN] = 1'b1;
      end else if (stall_i) begin
        hs_vld_o  = 1'b1;
        hs_code_o = HS_STALL;
      end else begin
        tx_o           = 1'b1;
        set_o[F_INRDY] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_ctrl_ep_flags.sv
module usb_ctrl_ep_flags
  import usb_ctrl_ep_pkg::*;
#(
  parameter int unsigned   NF      = NUM_FLAGS,
  parameter logic [NF-1:0] RST_VAL = FLAG_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          we_i,
  input  logic [NF-1:0] wdata_i,
  output logic [NF-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic clr;
    assign clr = we_i & ~wdata_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= RST_VAL[g];
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr)      q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_ctrl_ep_bank.sv
module usb_ctrl_ep_bank
  import usb_ctrl_ep_pkg::*;
#(
  parameter bit          IS_CTRL = 1'b1,
  parameter int unsigned BW      = BANK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rd_o
);
  if (IS_CTRL) begin : g_ctrl
    logic wr_unused;
    assign wr_unused = ^{clk_i, rst_ni, we_i, wdata_i};
    assign rd_o      = '0;
  end else begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_o <= '0;
      else if (we_i) rd_o <= wdata_i;
    end
  end
endmodule

// File: rtl/usb_ctrl_ep_hs.sv
module usb_ctrl_ep_hs
  import usb_ctrl_ep_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAGS,
  parameter int unsigned BW = BANK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_setup_i,
  input  logic          tok_out_i,
  input  logic          tok_in_i,
  input  logic          rx_ok_i,
  input  logic          retry_i,
  input  logic          fw_flag_we_i,
  input  logic [NF-1:0] fw_flag_wdata_i,
  input  logic          fw_stall_we_i,
  input  logic          fw_stall_i,
  input  logic          fw_bank_we_i,
  input  logic [BW-1:0] fw_bank_wdata_i,
  output logic          hs_valid_o,
  output logic [1:0]    hs_code_o,
  output logic          tx_data_o,
  output logic [NF-1:0] flags_o,
  output logic          stall_req_o,
  output logic [BW-1:0] bank_rd_o
);
  logic          hs_vld_d, tx_d, clr_stall;
  hs_code_e      hs_code_d;
  logic [NF-1:0] flag_set;

  usb_ctrl_ep_resp #(.NF(NF)) u_resp (
    .tok_setup_i (tok_setup_i),
    .tok_out_i   (tok_out_i),
    .tok_in_i    (tok_in_i),
    .rx_ok_i     (rx_ok_i),
    .retry_i     (retry_i),
    .stall_i     (stall_req_o),
    .flags_i     (flags_o),
    .hs_vld_o    (hs_vld_d),
    .hs_code_o   (hs_code_d),
    .tx_o        (tx_d),
    .set_o       (flag_set),
    .clr_stall_o (clr_stall)
  );

  usb_ctrl_ep_flags #(.NF(NF)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .we_i    (fw_flag_we_i),
    .wdata_i (fw_flag_wdata_i),
    .q_o     (flags_o)
  );

  usb_ctrl_ep_bank #(.IS_CTRL(1'b1), .BW(BW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fw_bank_we_i),
    .wdata_i (fw_bank_wdata_i),
    .rd_o    (bank_rd_o)
  );

  // setup recovery beats a firmware write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            stall_req_o <= 1'b0;
    else if (clr_stall)     stall_req_o <= 1'b0;
    else if (fw_stall_we_i) stall_req_o <= fw_stall_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_valid_o <= 1'b0;
      hs_code_o  <= HS_NONE;
      tx_data_o  <= 1'b0;
    end else begin
      hs_valid_o <= hs_vld_d;
      hs_code_o  <= hs_code_d;
      tx_data_o  <= tx_d;
    end
  end
endmodule

// File: rtl/usb_ctrl_ep_hs_chk.sv
module usb_ctrl_ep_hs_chk
  import usb_ctrl_ep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tok_setup_i,
  input logic       tok_out_i,
  input logic       tok_in_i,
  input logic       rx_ok_i,
  input logic       retry_i,
  input logic       hs_valid_o,
  input logic [1:0] hs_code_o,
  input logic [3:0] flags_o,
  input logic       stall_req_o
);
  logic good_setup;
  assign good_setup = tok_setup_i && rx_ok_i;

  p_retry_nak_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((tok_out_i && rx_ok_i) || tok_in_i) && retry_i && !tok_setup_i)
    |=> (hs_valid_o && hs_code_o == HS_NAK));

  p_stall_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && hs_code_o == HS_STALL) |-> ($past(stall_req_o) && !$past(retry_i)));

  p_setup_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_setup |=> (hs_valid_o && hs_code_o == HS_ACK));

  p_out_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_OUT]) |-> ($past(tok_out_i) && !$past(tok_setup_i)));

  p_busy_nak_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_out_i && rx_ok_i && !tok_setup_i && !retry_i && !stall_req_o
     && (flags_o[F_SETUP] || flags_o[F_OUT]))
    |=> (hs_valid_o && hs_code_o == HS_NAK));

  p_in_nak_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && hs_code_o == HS_NAK && $past(tok_in_i)) |-> flags_o[F_NAKIN]);

  p_setup_unstall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_setup |=> !stall_req_o);

  p_reply_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> $past(tok_setup_i || tok_out_i || tok_in_i));
endmodule

bind usb_ctrl_ep_hs usb_ctrl_ep_hs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tok_setup_i (tok_setup_i),
  .tok_out_i   (tok_out_i),
  .tok_in_i    (tok_in_i),
  .rx_ok_i     (rx_ok_i),
  .retry_i     (retry_i),
  .hs_valid_o  (hs_valid_o),
  .hs_code_o   (hs_code_o),
  .flags_o     (flags_o),
  .stall_req_o (stall_req_o)
);

// File: tb/usb_ctrl_ep_hs_bench.sv
module usb_ctrl_ep_hs_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tok_setup_i = 0, tok_out_i = 0, tok_in_i = 0, rx_ok_i = 0, retry_i = 0;
  logic       fw_flag_we_i = 0;
  logic [3:0] fw_flag_wdata_i = '1;
  logic       fw_stall_we_i = 0, fw_stall_i = 0, fw_bank_we_i = 0;
  logic [1:0] fw_bank_wdata_i = '0;
  logic       hs_valid_o, tx_data_o, stall_req_o;
  logic [1:0] hs_code_o, bank_rd_o;
  logic [3:0] flags_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_ctrl_ep_hs u_usb_ctrl_ep_hs (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive a token at a negedge, sample the reply at the following negedge
  task automatic tok(bit s, bit o, bit i, bit ok, bit rt);
    @(negedge clk_i);
    tok_setup_i = s; tok_out_i = o; tok_in_i = i; rx_ok_i = ok; retry_i = rt;
    @(negedge clk_i);
    tok_setup_i = 0; tok_out_i = 0; tok_in_i = 0; rx_ok_i = 0; retry_i = 0;
  endtask

  task automatic fw_flags(logic [3:0] d);
    @(negedge clk_i);
    fw_flag_we_i = 1; fw_flag_wdata_i = d;
    @(negedge clk_i);
    fw_flag_we_i = 0; fw_flag_wdata_i = '1;
  endtask

  task automatic fw_stall(bit v);
    @(negedge clk_i);
    fw_stall_we_i = 1; fw_stall_i = v;
    @(negedge clk_i);
    fw_stall_we_i = 0;
  endtask

  task automatic t_reset;
    chk("R7", "in_ready after reset", flags_o, 4'b0100);
    chk("R12", "hs_valid after reset", hs_valid_o, 0);
    chk("R2", "stall after reset", stall_req_o, 0);
    chk("R10", "bank after reset", bank_rd_o, 0);
  endtask

  task automatic t_setup;
    tok(1, 0, 0, 1, 0);
    chk("R3", "setup hs_valid", hs_valid_o, 1);
    chk("R3", "setup code", hs_code_o, 1);
    chk("R4", "setup flags", flags_o, 4'b0101);
    @(negedge clk_i);
    chk("R12", "reply one cycle", hs_valid_o, 0);
    fw_flags(4'b1110);
    chk("R9", "clear setup only", flags_o, 4'b0100);
    tok(1, 0, 0, 0, 0);
    chk("R3", "bad setup no reply", hs_valid_o, 0);
    chk("R3", "bad setup no flag", flags_o, 4'b0100);
    tok(0, 1, 0, 0, 0);
    chk("R3", "bad out no reply", hs_valid_o, 0);
  endtask

  task automatic t_out;
    tok(0, 1, 0, 1, 0);
    chk("R5", "out ack", {hs_valid_o, hs_code_o}, 3'b101);
    chk("R5", "out flag", flags_o, 4'b0110);
    tok(0, 1, 0, 1, 0);
    chk("R6", "out busy nak", {hs_valid_o, hs_code_o}, 3'b110);
    chk("R6", "flags kept", flags_o, 4'b0110);
    fw_flags(4'b1101);
    chk("R5", "out cleared", flags_o, 4'b0100);
    tok(1, 0, 0, 1, 0);
    tok(0, 1, 0, 1, 0);
    chk("R6", "out after setup nak", {hs_valid_o, hs_code_o}, 3'b110);
    chk("R4", "out flag still clear", flags_o[1], 0);
    fw_flags(4'b1110);
  endtask

  task automatic t_prio;
    fw_stall(1);
    chk("R2", "stall set", stall_req_o, 1);
    tok(0, 1, 0, 1, 1);
    chk("R1", "out retry over stall", {hs_valid_o, hs_code_o}, 3'b110);
    tok(0, 1, 0, 1, 0);
    chk("R2", "out stall", {hs_valid_o, hs_code_o}, 3'b111);
    chk("R2", "out stall no flag", flags_o, 4'b0100);
    tok(0, 0, 1, 0, 1);
    chk("R1", "in retry nak", {hs_valid_o, hs_code_o}, 3'b110);
    chk("R8", "retry nak sets nak_in", flags_o[3], 1);
    fw_flags(4'b0111);
    tok(0, 0, 1, 0, 0);
    chk("R2", "in stall", {hs_valid_o, hs_code_o}, 3'b111);
    chk("R8", "stall leaves nak_in", flags_o[3], 0);
    tok(1, 0, 0, 1, 1);
    chk("R3", "setup ack despite retry+stall", {hs_valid_o, hs_code_o}, 3'b101);
    chk("R11", "setup clears stall", stall_req_o, 0);
    fw_flags(4'b1110);
    // stall write coinciding with setup
    @(negedge clk_i);
    fw_stall_we_i = 1; fw_stall_i = 1;
    tok_setup_i = 1; rx_ok_i = 1;
    @(negedge clk_i);
    fw_stall_we_i = 0; tok_setup_i = 0; rx_ok_i = 0;
    chk("R11", "setup beats stall write", stall_req_o, 0);
    fw_flags(4'b1110);
  endtask

  task automatic t_in;
    tok(0, 0, 1, 0, 0);
    chk("R7", "in while ready nak", {hs_valid_o, hs_code_o}, 3'b110);
    chk("R8", "nak_in set", flags_o, 4'b1100);
    fw_flags(4'b0011);
    chk("R7", "in_ready cleared", flags_o, 4'b0000);
    tok(0, 0, 1, 0, 0);
    chk("R7", "in sends data", {hs_valid_o, tx_data_o}, 2'b01);
    chk("R7", "in_ready back", flags_o, 4'b0100);
    @(negedge clk_i);
    chk("R12", "tx one cycle", tx_data_o, 0);
  endtask

  task automatic t_flag_write;
    fw_flags(4'b1111);
    chk("R9", "write ones no effect", flags_o, 4'b0100);
    @(negedge clk_i);
    fw_flag_we_i = 1; fw_flag_wdata_i = 4'b0000;
    tok_out_i = 1; rx_ok_i = 1;
    @(negedge clk_i);
    fw_flag_we_i = 0; fw_flag_wdata_i = '1; tok_out_i = 0; rx_ok_i = 0;
    chk("R9", "set wins over clear", flags_o, 4'b0010);
    fw_flags(4'b1101);
  endtask

  task automatic t_bank;
    @(negedge clk_i);
    fw_bank_we_i = 1; fw_bank_wdata_i = 2'b11;
    @(negedge clk_i);
    fw_bank_we_i = 0;
    @(negedge clk_i);
    chk("R10", "bank reads zero after write", bank_rd_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1;
    @(negedge clk_i);
    t_setup;
    t_out;
    t_prio;
    t_in;
    t_flag_write;
    t_bank;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule